// File: doc/BRIEF.md
# Packet Event Timestamp Capture Queue

This block stamps timing-protocol event messages as they pass the line interface. Whenever a start-of-packet strobe arrives together with the message's sideband fields, the block may accept it. It accepts the strobe only when the message type is an event type and capture is switched on for that direction. An accepted strobe stores one record in a small in-order queue. The record holds the current seconds and nanoseconds from the time bus, the 16-bit sequence id, the 4-bit message type and a transmit/receive flag.

Software reads records through 16-bit words with a two-step handshake. A read-start write copies the oldest record into a set of holding registers. Those registers stay fixed while software reads them, even if new captures arrive. A read-end write followed by a write of zero removes that record from the queue. A status output shows that at least one record is waiting. A sticky flag reports captures that were lost because the queue was full.

Top module: `pkt_ts_capture`

## Requirements
- R1: After reset the record-waiting flag and the overflow flag are 0, and all six output words are 0.
- R2: A transmit strobe (`sop_is_tx`=1) is stored only while `tx_cap_en` is 1. A receive strobe (`sop_is_tx`=0) is stored only while `rx_cap_en` is 1. Other strobes leave the queue unchanged.
- R3: Only message types 0 to 3 are stored. A strobe carrying type 4 to 15 leaves the queue unchanged.
- R4: The time words of a record read out as follows: `ts_w0` = nsec[15:0], `ts_w1` = nsec[31:16], `ts_w2` = sec[15:0], `ts_w3` = sec[31:16]. The sampled values are those on the time bus in the cycle of the strobe.
- R5: `seq_word` carries the sequence id exactly as received, with no byte swap. `info_word` carries the message type in bits 15:12 and the direction in bit 11 (1 = transmit), with bits 10:0 at 0.
- R6: `rec_avail` is 1 exactly while the queue holds at least one record. It is 1 from the cycle after the first store.
- R7: A control write with bit 0 set (read-start), made while idle and with a record waiting, loads the oldest record into the output words. The output words change at no other time, and later captures do not disturb them.
- R8: After a read-start, a write with bit 1 set (read-end) and then a write of 0 removes the record. Records leave in the order they were stored.
- R9: The queue holds DEPTH (default 8) records. A strobe that would otherwise be stored while DEPTH records are held is dropped, even if a removal happens in the same cycle. Such a strobe sets `overflow`, which stays 1 until reset.
- R10: The handshake is ignored in two cases. A read-start with the queue empty does not change the output words. A read-end or zero write without a preceding read-start removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_cap_en | input | 1 | Enables storing of transmit-direction events |
| rx_cap_en | input | 1 | Enables storing of receive-direction events |
| time_sec | input | 32 | Current seconds from the time source |
| time_nsec | input | 32 | Current nanoseconds from the time source |
| sop_stb | input | 1 | Start-of-packet capture strobe, one cycle |
| sop_is_tx | input | 1 | Direction of the strobed packet, 1 = transmit |
| sop_msg_type | input | 4 | Message type of the strobed packet |
| sop_seq_id | input | 16 | Sequence id of the strobed packet |
| ctrl_wr_en | input | 1 | Write strobe of the read-control word |
| ctrl_wr_data | input | 2 | Read-control data: bit 0 read-start, bit 1 read-end |
| rec_avail | output | 1 | At least one record waits in the queue |
| overflow | output | 1 | Sticky: a capture was dropped on a full queue |
| ts_w0 | output | 16 | Held record, nanoseconds low half |
| ts_w1 | output | 16 | Held record, nanoseconds high half |
| ts_w2 | output | 16 | Held record, seconds low half |
| ts_w3 | output | 16 | Held record, seconds high half |
| seq_word | output | 16 | Held record, sequence id |
| info_word | output | 16 | Held record, type in [15:12], direction in [11] |

## Verification
The hardest case to reach from the ports is a full queue that is also being read. Here a capture is dropped, the held words must stay frozen, and the removal order must still be intact. The bench fills the queue with DEPTH+1 strobes carrying ascending sequence ids. It then opens a read window and sends more strobes while that window is open. It drains the queue and checks that it sees exactly the first DEPTH ids, in order, with the overflow flag still set.

// File: rtl/pts_pkg.sv
package pts_pkg;

   localparam int SEC_W  = 32;
   localparam int NSEC_W = 32;
   localparam int SEQ_W  = 16;
   localparam int TYPE_W = 4;
   localparam int WORD_W = 16;

   // read-control bit positions
   localparam int CTRL_START_BIT = 0;
   localparam int CTRL_END_BIT   = 1;
   localparam int CTRL_W         = 2;

   typedef struct packed {
      logic [SEC_W-1:0]  sec;
      logic [NSEC_W-1:0] nsec;
      logic [SEQ_W-1:0]  seq;
      logic [TYPE_W-1:0] mtype;
      logic              is_tx;
   } ts_rec_t;

   typedef enum logic [1:0] {
      RD_IDLE    = 2'd0,
      RD_HELD    = 2'd1,
      RD_CLOSING = 2'd2
   } rd_state_t;

endpackage

// File: rtl/pts_event_filter.sv
module pts_event_filter
   import pts_pkg::*;
#(
   parameter int MAX_EVENT_TYPE = 3
) (
   input  logic              stb,
   input  logic              is_tx,
   input  logic [TYPE_W-1:0] mtype,
   input  logic              tx_en,
   input  logic              rx_en,
   output logic              accept
);

   localparam logic [TYPE_W-1:0] TYPE_LIMIT = TYPE_W'(MAX_EVENT_TYPE);

   if (MAX_EVENT_TYPE < 0 || MAX_EVENT_TYPE >= (1 << TYPE_W)) begin : g_bad_limit
      $error("pts_event_filter: MAX_EVENT_TYPE out of range");
   end

   logic dir_on;
   logic is_event;

   always_comb begin
      dir_on   = is_tx ? tx_en : rx_en;
      is_event = (mtype <= TYPE_LIMIT);
      accept   = stb && dir_on && is_event;
   end

endmodule

// File: rtl/pts_rec_fifo.sv
module pts_rec_fifo
   import pts_pkg::*;
#(
   parameter int DEPTH = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        push,
   input  ts_rec_t                     wr_rec,
   input  logic                        pop,
   output ts_rec_t                     head_rec,
   output logic [$clog2(DEPTH+1)-1:0]  fill_cnt,
   output logic                        full,
   output logic                        empty
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH+1);
   localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH-1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
   localparam bit   IS_POW2  = ((DEPTH & (DEPTH-1)) == 0);

   if (DEPTH < 2) begin : g_bad_depth
      $error("pts_rec_fifo: DEPTH must be at least 2");
   end

   ts_rec_t          mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [PTR_W-1:0] wr_nxt, rd_nxt;
   logic [CNT_W-1:0] cnt;
   logic             do_push, do_pop;

   // pointer advance: natural wrap for powers of two, compare otherwise
   if (IS_POW2) begin : g_wrap_pow2
      always_comb begin
         wr_nxt = wr_ptr + 1'b1;
         rd_nxt = rd_ptr + 1'b1;
      end
   end else begin : g_wrap_cmp
      always_comb begin
         wr_nxt = (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
         rd_nxt = (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
      end
   end

   always_comb begin
      full    = (cnt == FULL_CNT);
      empty   = (cnt == '0);
      do_push = push && !full;
      do_pop  = pop && !empty;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wr_rec;
   end

   assign head_rec = mem[rd_ptr];
   assign fill_cnt = cnt;

endmodule

// File: rtl/pts_read_port.sv
module pts_read_port
   import pts_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr_en,
   input  logic [CTRL_W-1:0] ctrl_wr_data,
   input  logic              have_rec,
   input  ts_rec_t           head_rec,
   output logic              pop,
   output logic [WORD_W-1:0] w_nsec_lo,
   output logic [WORD_W-1:0] w_nsec_hi,
   output logic [WORD_W-1:0] w_sec_lo,
   output logic [WORD_W-1:0] w_sec_hi,
   output logic [WORD_W-1:0] w_seq,
   output logic [WORD_W-1:0] w_info
);

   localparam int INFO_PAD = WORD_W - TYPE_W - 1;

   rd_state_t state, state_nxt;
   ts_rec_t   held;
   logic      wr_start, wr_end, wr_zero, load;

   always_comb begin
      wr_start  = ctrl_wr_en && ctrl_wr_data[CTRL_START_BIT];
      wr_end    = ctrl_wr_en && ctrl_wr_data[CTRL_END_BIT];
      wr_zero   = ctrl_wr_en && (ctrl_wr_data == '0);
      load      = 1'b0;
      pop       = 1'b0;
      state_nxt = state;
      case (state)
         RD_IDLE: begin
            if (wr_start && have_rec) begin
               load      = 1'b1;
               state_nxt = RD_HELD;
            end
         end
         RD_HELD: begin
            if (wr_end) state_nxt = RD_CLOSING;
         end
         RD_CLOSING: begin
            if (wr_zero) begin
               pop       = 1'b1;
               state_nxt = RD_IDLE;
            end
         end
         default: state_nxt = RD_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= RD_IDLE;
         held  <= '0;
      end else begin
         state <= state_nxt;
         if (load) held <= head_rec;
      end
   end

   always_comb begin
      w_nsec_lo = held.nsec[WORD_W-1:0];
      w_nsec_hi = held.nsec[2*WORD_W-1:WORD_W];
      w_sec_lo  = held.sec[WORD_W-1:0];
      w_sec_hi  = held.sec[2*WORD_W-1:WORD_W];
      w_seq     = held.seq;
      w_info    = {held.mtype, held.is_tx, {INFO_PAD{1'b0}}};
   end

endmodule

// File: rtl/pkt_ts_capture.sv
module pkt_ts_capture
   import pts_pkg::*;
#(
   parameter int DEPTH          = 8,
   parameter int MAX_EVENT_TYPE = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_cap_en,
   input  logic              rx_cap_en,
   input  logic [31:0]       time_sec,
   input  logic [31:0]       time_nsec,
   input  logic              sop_stb,
   input  logic              sop_is_tx,
   input  logic [3:0]        sop_msg_type,
   input  logic [15:0]       sop_seq_id,
   input  logic              ctrl_wr_en,
   input  logic [1:0]        ctrl_wr_data,
   output logic              rec_avail,
   output logic              overflow,
   output logic [15:0]       ts_w0,
   output logic [15:0]       ts_w1,
   output logic [15:0]       ts_w2,
   output logic [15:0]       ts_w3,
   output logic [15:0]       seq_word,
   output logic [15:0]       info_word
);

   localparam int CNT_W = $clog2(DEPTH+1);

   logic             accept;
   logic             q_full, q_empty, q_pop;
   logic [CNT_W-1:0] fill_cnt;
   ts_rec_t          new_rec, head_rec;
   logic             ovf_q;

   pts_event_filter #(.MAX_EVENT_TYPE(MAX_EVENT_TYPE)) u_filter (
      .stb    (sop_stb),
      .is_tx  (sop_is_tx),
      .mtype  (sop_msg_type),
      .tx_en  (tx_cap_en),
      .rx_en  (rx_cap_en),
      .accept (accept)
   );

   always_comb begin
      new_rec.sec   = time_sec;
      new_rec.nsec  = time_nsec;
      new_rec.seq   = sop_seq_id;
      new_rec.mtype = sop_msg_type;
      new_rec.is_tx = sop_is_tx;
   end

   pts_rec_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (accept),
      .wr_rec   (new_rec),
      .pop      (q_pop),
      .head_rec (head_rec),
      .fill_cnt (fill_cnt),
      .full     (q_full),
      .empty    (q_empty)
   );

   pts_read_port u_rd (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctrl_wr_en   (ctrl_wr_en),
      .ctrl_wr_data (ctrl_wr_data),
      .have_rec     (!q_empty),
      .head_rec     (head_rec),
      .pop          (q_pop),
      .w_nsec_lo    (ts_w0),
      .w_nsec_hi    (ts_w1),
      .w_sec_lo     (ts_w2),
      .w_sec_hi     (ts_w3),
      .w_seq        (seq_word),
      .w_info       (info_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)                 ovf_q <= 1'b0;
      else if (accept && q_full)  ovf_q <= 1'b1;
   end

   assign overflow  = ovf_q;
   assign rec_avail = !q_empty;

endmodule

// File: rtl/pts_capture_chk.sv
module pts_capture_chk #(
   parameter int DEPTH          = 8,
   parameter int MAX_EVENT_TYPE = 3
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        tx_cap_en,
   input logic                        rx_cap_en,
   input logic                        sop_stb,
   input logic                        sop_is_tx,
   input logic [3:0]                  sop_msg_type,
   input logic                        ctrl_wr_en,
   input logic [1:0]                  ctrl_wr_data,
   input logic                        rec_avail,
   input logic                        overflow,
   input logic [95:0]                 out_words,
   input logic [$clog2(DEPTH+1)-1:0]  fill_cnt
);

   // R9
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   // R9
   ovf_only_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overflow) |-> ($past(fill_cnt) == ($clog2(DEPTH+1))'(DEPTH)) && $past(sop_stb));

   // R7
   words_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctrl_wr_en && ctrl_wr_data[0]) |=> $stable(out_words));

   // R6
   avail_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rec_avail) |-> $past(sop_stb));

   // R3
   non_event_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sop_stb && (sop_msg_type > 4'(MAX_EVENT_TYPE)) && !rec_avail) |=> !rec_avail);

   // R2
   dir_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sop_stb && !rec_avail && ((sop_is_tx && !tx_cap_en) || (!sop_is_tx && !rx_cap_en)))
      |=> !rec_avail);

endmodule

bind pkt_ts_capture pts_capture_chk #(
   .DEPTH          (DEPTH),
   .MAX_EVENT_TYPE (MAX_EVENT_TYPE)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tx_cap_en    (tx_cap_en),
   .rx_cap_en    (rx_cap_en),
   .sop_stb      (sop_stb),
   .sop_is_tx    (sop_is_tx),
   .sop_msg_type (sop_msg_type),
   .ctrl_wr_en   (ctrl_wr_en),
   .ctrl_wr_data (ctrl_wr_data),
   .rec_avail    (rec_avail),
   .overflow     (overflow),
   .out_words    ({ts_w0, ts_w1, ts_w2, ts_w3, seq_word, info_word}),
   .fill_cnt     (fill_cnt)
);

// File: tb/pkt_ts_capture_test.sv
module pkt_ts_capture_test;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 8;
   localparam int NVEC       = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_cap_en = 1'b0, rx_cap_en = 1'b0;
   logic [31:0] time_sec = '0, time_nsec = '0;
   logic        sop_stb = 1'b0, sop_is_tx = 1'b0;
   logic [3:0]  sop_msg_type = '0;
   logic [15:0] sop_seq_id = '0;
   logic        ctrl_wr_en = 1'b0;
   logic [1:0]  ctrl_wr_data = '0;
   logic        rec_avail, overflow;
   logic [15:0] ts_w0, ts_w1, ts_w2, ts_w3, seq_word, info_word;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pkt_ts_capture #(.DEPTH(DEPTH)) uut (
      .clk(clk), .rst_n(rst_n), .tx_cap_en(tx_cap_en), .rx_cap_en(rx_cap_en),
      .time_sec(time_sec), .time_nsec(time_nsec), .sop_stb(sop_stb),
      .sop_is_tx(sop_is_tx), .sop_msg_type(sop_msg_type), .sop_seq_id(sop_seq_id),
      .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data),
      .rec_avail(rec_avail), .overflow(overflow),
      .ts_w0(ts_w0), .ts_w1(ts_w1), .ts_w2(ts_w2), .ts_w3(ts_w3),
      .seq_word(seq_word), .info_word(info_word)
   );

   typedef struct packed {
      logic        tx;
      logic [3:0]  mt;
      logic [15:0] seq;
      logic [31:0] sec;
      logic [31:0] ns;
      logic        keep;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{1'b1, 4'd0,  16'h0001, 32'h0000_0010, 32'h1234_5678, 1'b1},
      '{1'b0, 4'd1,  16'hABCD, 32'hDEAD_BEEF, 32'h3B9A_C9FF, 1'b1},
      '{1'b1, 4'd2,  16'h8000, 32'hFFFF_FFFF, 32'h0000_0000, 1'b1},
      '{1'b0, 4'd3,  16'h00FF, 32'h0000_0001, 32'h0000_0001, 1'b1},
      '{1'b1, 4'd8,  16'h1111, 32'h0000_0022, 32'h0000_0033, 1'b0},
      '{1'b0, 4'd11, 16'h2222, 32'h0000_0044, 32'h0000_0055, 1'b0},
      '{1'b0, 4'd4,  16'h3333, 32'h0000_0066, 32'h0000_0077, 1'b0},
      '{1'b1, 4'd15, 16'h4444, 32'h0000_0088, 32'h0000_0099, 1'b0}
   };

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic capture(input logic tx, input logic [3:0] mt, input logic [15:0] seq,
                          input logic [31:0] sec, input logic [31:0] ns);
      @(negedge clk);
      sop_stb = 1'b1; sop_is_tx = tx; sop_msg_type = mt; sop_seq_id = seq;
      time_sec = sec; time_nsec = ns;
      @(negedge clk);
      sop_stb = 1'b0;
      time_sec = ~sec; time_nsec = ~ns;
   endtask

   task automatic ctrl(input logic [1:0] d);
      @(negedge clk);
      ctrl_wr_en = 1'b1; ctrl_wr_data = d;
      @(negedge clk);
      ctrl_wr_en = 1'b0; ctrl_wr_data = '0;
   endtask

   task automatic check_words(input logic tx, input logic [3:0] mt, input logic [15:0] seq,
                              input logic [31:0] sec, input logic [31:0] ns, input string req);
      logic [95:0] act, exp;
      act = {ts_w0, ts_w1, ts_w2, ts_w3, seq_word, info_word};
      exp = {ns[15:0], ns[31:16], sec[15:0], sec[31:16], seq, {mt, tx, 11'b0}};
      chk(act == exp, req, act[63:0], exp[63:0]);
      chk(act[95:64] == exp[95:64], req, 64'(act[95:64]), 64'(exp[95:64]));
   endtask

   task automatic read_expect(input logic tx, input logic [3:0] mt, input logic [15:0] seq,
                              input logic [31:0] sec, input logic [31:0] ns, input string req);
      ctrl(2'b01);
      check_words(tx, mt, seq, sec, ns, req);
      ctrl(2'b10);
      ctrl(2'b00);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      do_reset();
      @(negedge clk);
      // R1 reset state
      chk(rec_avail == 1'b0, "R1 rec_avail", 64'(rec_avail), 64'd0);
      chk(overflow == 1'b0, "R1 overflow", 64'(overflow), 64'd0);
      chk({ts_w0, ts_w1, ts_w2, ts_w3, seq_word, info_word} == '0, "R1 words",
          64'({ts_w0, ts_w1, ts_w2, ts_w3}), 64'd0);

      // table walk: R3 R4 R5 R6 R8
      tx_cap_en = 1'b1; rx_cap_en = 1'b1;
      for (int i = 0; i < NVEC; i++) begin
         capture(VECS[i].tx, VECS[i].mt, VECS[i].seq, VECS[i].sec, VECS[i].ns);
         if (VECS[i].keep) begin
            chk(rec_avail == 1'b1, "R6 avail after store", 64'(rec_avail), 64'd1);
            read_expect(VECS[i].tx, VECS[i].mt, VECS[i].seq, VECS[i].sec, VECS[i].ns,
                        "R4 R5 record words");
            chk(rec_avail == 1'b0, "R8 removed after end/zero", 64'(rec_avail), 64'd0);
         end else begin
            chk(rec_avail == 1'b0, "R3 non-event ignored", 64'(rec_avail), 64'd0);
         end
      end

      // R2 direction gating
      tx_cap_en = 1'b0; rx_cap_en = 1'b1;
      capture(1'b1, 4'd0, 16'h5555, 32'd5, 32'd6);
      chk(rec_avail == 1'b0, "R2 tx gated off", 64'(rec_avail), 64'd0);
      capture(1'b0, 4'd1, 16'h6666, 32'd7, 32'd8);
      chk(rec_avail == 1'b1, "R2 rx enabled", 64'(rec_avail), 64'd1);
      read_expect(1'b0, 4'd1, 16'h6666, 32'd7, 32'd8, "R2 rx record");
      tx_cap_en = 1'b1; rx_cap_en = 1'b0;
      capture(1'b0, 4'd2, 16'h7777, 32'd9, 32'd10);
      chk(rec_avail == 1'b0, "R2 rx gated off", 64'(rec_avail), 64'd0);
      capture(1'b1, 4'd3, 16'h8888, 32'd11, 32'd12);
      read_expect(1'b1, 4'd3, 16'h8888, 32'd11, 32'd12, "R2 tx record");
      rx_cap_en = 1'b1;

      // R10 handshake misuse
      do_reset();
      ctrl(2'b01);
      chk({ts_w0, ts_w1, ts_w2, ts_w3} == '0, "R10 start on empty", 64'({ts_w0, ts_w1, ts_w2, ts_w3}), 64'd0);
      capture(1'b1, 4'd0, 16'h0A0A, 32'h100, 32'h200);
      ctrl(2'b10);
      ctrl(2'b00);
      chk(rec_avail == 1'b1, "R10 end without start", 64'(rec_avail), 64'd1);
      ctrl(2'b01);
      ctrl(2'b00);
      chk(rec_avail == 1'b1, "R10 zero without end", 64'(rec_avail), 64'd1);
      ctrl(2'b10);
      ctrl(2'b00);
      chk(rec_avail == 1'b0, "R8 removed", 64'(rec_avail), 64'd0);

      // R7 freeze while new captures arrive
      capture(1'b0, 4'd1, 16'hA001, 32'h11, 32'h22);
      ctrl(2'b01);
      capture(1'b1, 4'd2, 16'hA002, 32'h33, 32'h44);
      capture(1'b1, 4'd3, 16'hA003, 32'h55, 32'h66);
      check_words(1'b0, 4'd1, 16'hA001, 32'h11, 32'h22, "R7 held steady");
      ctrl(2'b10);
      check_words(1'b0, 4'd1, 16'hA001, 32'h11, 32'h22, "R7 held after end");
      ctrl(2'b00);
      read_expect(1'b1, 4'd2, 16'hA002, 32'h33, 32'h44, "R8 order 2nd");
      read_expect(1'b1, 4'd3, 16'hA003, 32'h55, 32'h66, "R8 order 3rd");

      // R9 overflow: fill, overflow, capture during held read, drain
      do_reset();
      for (int i = 0; i <= DEPTH; i++)
         capture(1'b1, 4'd0, 16'(100 + i), 32'(i), 32'(1000 + i));
      chk(overflow == 1'b1, "R9 overflow set", 64'(overflow), 64'd1);
      ctrl(2'b01);
      capture(1'b0, 4'd1, 16'h0BAD, 32'd1, 32'd1);
      check_words(1'b1, 4'd0, 16'd100, 32'd0, 32'd1000, "R9 R7 held on full");
      ctrl(2'b10);
      ctrl(2'b00);
      for (int i = 1; i < DEPTH; i++)
         read_expect(1'b1, 4'd0, 16'(100 + i), 32'(i), 32'(1000 + i), "R9 R8 drain order");
      chk(rec_avail == 1'b0, "R9 extra dropped", 64'(rec_avail), 64'd0);
      chk(overflow == 1'b1, "R9 overflow sticky", 64'(overflow), 64'd1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule